// File: doc/BRIEF.md
# Retirement-Updated Gshare Direction Predictor

This block predicts whether a conditional branch is taken and learns only from branches that have actually retired. A fetch stage presents a program counter. The block returns a taken/not-taken guess from a table of 2-bit saturating counters. The table is indexed by the word-aligned PC bits XOR-ed with a speculative global history. Each presented prediction is shifted into that speculative history at once, so that later fetches in the same window see it.

Permanent learning happens only on the retirement port. Retirement delivers branches in program order, one per cycle at most. Each retired branch trains its counter, which is indexed with a separate committed history, and then shifts its real outcome into that committed history. Branches on a wrong path, or squashed before retirement, therefore never touch the counters or the committed history.

A mispredict flush rebuilds the speculative history from the committed history plus the correct outcome of the offending branch. A context-switch flush clears both histories and keeps the counters as they are.

Top module: `commit_gshare_predictor`

## Requirements
- R1: After reset both history registers read 0 and every counter holds 1 (weakly not taken), so every prediction is not-taken.
- R2: predTaken equals bit 1 of the counter at index predPc[9:2] XOR specHist; it is combinational from the current state.
- R3: A cycle with predValid, and with no flush of either kind, loads specHist with {specHist[6:0], predTaken}.
- R4: A cycle with commitValid updates the counter at commitPc[9:2] XOR commitHist (the value before this cycle's shift): +1 if commitTaken, else -1.
- R5: A cycle with commitValid and without ctxFlush loads commitHist with {commitHist[6:0], commitTaken}.
- R6: predValid, predPc and flushValid never change any counter or commitHist.
- R7: flushValid without ctxFlush loads specHist with {C[6:0], flushTaken}, where C is the commitHist value after the same cycle's edge; this takes priority over predValid.
- R8: ctxFlush clears specHist and commitHist and overrides every other history update; counters keep their values, including any update from a retirement in the same cycle.
- R9: If a retirement writes the entry being read for a prediction in the same cycle, predTaken shows the value from before the write.
- R10: Counters saturate: an increment at 3 stays at 3 and a decrement at 0 stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predValid | input | 1 | A prediction is consumed this cycle |
| predPc | input | PC_W | PC of the branch being predicted |
| predTaken | output | 1 | Predicted direction |
| commitValid | input | 1 | A branch retires this cycle |
| commitPc | input | PC_W | PC of the retiring branch |
| commitTaken | input | 1 | Real outcome of the retiring branch |
| flushValid | input | 1 | Mispredict flush |
| flushTaken | input | 1 | Correct outcome of the mispredicted branch |
| ctxFlush | input | 1 | Context-switch flush |
| specHist | output | 8 | Speculative global history |
| commitHist | output | 8 | Committed global history |

## Verification
The bench first runs directed patterns. One series of taken retirements on a single entry, followed by a series of not-taken ones, tells saturation apart from wrap-around. A retirement and a prediction aimed at the same entry in one cycle tell old-value reads apart from write-through. A long stretch of predictions with no retirement shows whether speculative guesses leak into the table or into the committed history. Flushes that coincide with retirements expose which value of the committed history is used to rebuild the speculative one. A long random mix of all ports, over a small pool of PCs so that entries collide often, is then checked cycle by cycle against a behavioural model.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  localparam int HIST_W   = 8;
  localparam int IDX_W    = HIST_W;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int PC_LSB   = 2;
  localparam int CNT_W    = 2;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};

  typedef struct packed {
    logic             cntWr;
    logic             cntUp;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import bpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predTaken,
  input  logic              commitValid,
  input  logic [PC_W-1:0]   commitPc,
  input  logic              commitTaken,
  input  logic              flushValid,
  input  logic              flushTaken,
  input  logic              ctxFlush,
  output logic [HIST_W-1:0] specHist,
  output logic [HIST_W-1:0] commitHist,
  output ctlStrobe_t        strobe
);
  localparam int PC_HI = PC_LSB + IDX_W;

  logic [HIST_W-1:0] commitHistNext;
  logic [HIST_W-1:0] specHistNext;
  logic [IDX_W-1:0]  predPcBits;
  logic [IDX_W-1:0]  commitPcBits;

  logic unusedPcBits;
  assign unusedPcBits = ^{predPc[PC_W-1:PC_HI], predPc[PC_LSB-1:0],
                          commitPc[PC_W-1:PC_HI], commitPc[PC_LSB-1:0]};

  assign predPcBits   = predPc[PC_LSB +: IDX_W];
  assign commitPcBits = commitPc[PC_LSB +: IDX_W];

  always_comb begin
    strobe.rdIdx = predPcBits ^ IDX_W'(specHist);
    strobe.wrIdx = commitPcBits ^ IDX_W'(commitHist);
    strobe.cntWr = commitValid;
    strobe.cntUp = commitTaken;
  end

  always_comb begin
    if (ctxFlush)
      commitHistNext = '0;
    else if (commitValid)
      commitHistNext = {commitHist[HIST_W-2:0], commitTaken};
    else
      commitHistNext = commitHist;
  end

  always_comb begin
    if (ctxFlush)
      specHistNext = '0;
    else if (flushValid)
      specHistNext = {commitHistNext[HIST_W-2:0], flushTaken};
    else if (predValid)
      specHistNext = {specHist[HIST_W-2:0], predTaken};
    else
      specHistNext = specHist;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      specHist   <= '0;
      commitHist <= '0;
    end else begin
      specHist   <= specHistNext;
      commitHist <= commitHistNext;
    end
  end

  AST_CTX_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ctxFlush |=> (specHist == '0 && commitHist == '0)); // R8
  AST_COMMIT_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!commitValid && !ctxFlush) |=> $stable(commitHist)); // R6
  AST_COMMIT_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (commitValid && !ctxFlush) |=> commitHist[0] == $past(commitTaken)); // R5
  AST_FLUSH_REBUILD: assert property (@(posedge clk) disable iff (!rstN)
    (flushValid && !ctxFlush) |=>
      (specHist[0] == $past(flushTaken) && specHist[HIST_W-1:1] == commitHist[HIST_W-2:0])); // R7
  AST_PRED_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && !flushValid && !ctxFlush) |=>
      specHist == {$past(specHist[HIST_W-2:0]), $past(predTaken)}); // R3
endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import bpc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  output logic       predTaken
);
  logic [CNT_W-1:0] cntTab [DEPTH];
  logic [CNT_W-1:0] wrOld;
  logic [CNT_W-1:0] wrNew;

  assign wrOld = cntTab[strobe.wrIdx];

  always_comb begin
    if (strobe.cntUp)
      wrNew = (wrOld == CNT_MAX) ? wrOld : wrOld + CNT_W'(1);
    else
      wrNew = (wrOld == '0) ? wrOld : wrOld - CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        cntTab[g] <= CNT_INIT;
      else if (strobe.cntWr && strobe.wrIdx == IDX_W'(g))
        cntTab[g] <= wrNew;
    end
  end

  assign predTaken = cntTab[strobe.rdIdx][CNT_W-1];

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntWr && strobe.cntUp && wrOld == CNT_MAX) |=>
      cntTab[$past(strobe.wrIdx)] == CNT_MAX); // R10
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntWr && !strobe.cntUp && wrOld == '0) |=>
      cntTab[$past(strobe.wrIdx)] == '0); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntWr && wrOld != '0 && wrOld != CNT_MAX) |=>
      cntTab[$past(strobe.wrIdx)] != $past(wrOld)); // R4
endmodule

// File: rtl/commit_gshare_predictor.sv
module commit_gshare_predictor
  import bpc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              predValid,
  input  logic [PC_W-1:0]   predPc,
  output logic              predTaken,
  input  logic              commitValid,
  input  logic [PC_W-1:0]   commitPc,
  input  logic              commitTaken,
  input  logic              flushValid,
  input  logic              flushTaken,
  input  logic              ctxFlush,
  output logic [HIST_W-1:0] specHist,
  output logic [HIST_W-1:0] commitHist
);
  ctlStrobe_t strobe;

  gshare_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predPc(predPc), .predTaken(predTaken),
    .commitValid(commitValid), .commitPc(commitPc), .commitTaken(commitTaken),
    .flushValid(flushValid), .flushTaken(flushTaken), .ctxFlush(ctxFlush),
    .specHist(specHist), .commitHist(commitHist), .strobe(strobe)
  );

  gshare_table u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .predTaken(predTaken)
  );
endmodule

// File: tb/tb_commit_gshare_predictor.sv
module tb_commit_gshare_predictor;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        predValid = 1'b0, commitValid = 1'b0, commitTaken = 1'b0;
  logic        flushValid = 1'b0, flushTaken = 1'b0, ctxFlush = 1'b0;
  logic [31:0] predPc = '0, commitPc = '0;
  logic        predTaken;
  logic [7:0]  specHist, commitHist;

  int   nTests = 0;
  int   nFail = 0;
  bit   finished = 0;
  int   mCnt [256];
  bit [7:0] mSpec, mCommit;

  always #10 clk = ~clk;

  commit_gshare_predictor dut (
    .clk(clk), .rstN(rstN),
    .predValid(predValid), .predPc(predPc), .predTaken(predTaken),
    .commitValid(commitValid), .commitPc(commitPc), .commitTaken(commitTaken),
    .flushValid(flushValid), .flushTaken(flushTaken), .ctxFlush(ctxFlush),
    .specHist(specHist), .commitHist(commitHist)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int idxOf(input bit [31:0] pc, input bit [7:0] h);
    return ((pc >> 2) ^ h) & 255;
  endfunction

  task automatic step(input string tag, input bit pv, input bit [31:0] ppc,
                      input bit cv, input bit [31:0] cpc, input bit ct,
                      input bit fv, input bit ft, input bit cf);
    bit       expPred;
    bit [7:0] nc, ns;
    int       wi;
    @(negedge clk);
    predValid = pv; predPc = ppc; commitValid = cv; commitPc = cpc;
    commitTaken = ct; flushValid = fv; flushTaken = ft; ctxFlush = cf;
    #1;
    expPred = (mCnt[idxOf(ppc, mSpec)] >= 2);
    check({tag, " R2 prediction"}, int'(predTaken), int'(expPred));
    check({tag, " R3/R7/R8 specHist"}, int'(specHist), int'(mSpec));
    check({tag, " R5/R6 commitHist"}, int'(commitHist), int'(mCommit));
    nc = cf ? 8'h00 : (cv ? {mCommit[6:0], ct} : mCommit);
    ns = cf ? 8'h00 : (fv ? {nc[6:0], ft} : (pv ? {mSpec[6:0], expPred} : mSpec));
    wi = idxOf(cpc, mCommit);
    @(posedge clk);
    if (cv) begin
      if (ct && mCnt[wi] < 3) mCnt[wi]++;
      else if (!ct && mCnt[wi] > 0) mCnt[wi]--;
    end
    mSpec = ns; mCommit = nc;
  endtask

  task automatic idle(input string tag, input bit [31:0] ppc);
    step(tag, 0, ppc, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mCnt[i] = 1;
    mSpec = 0; mCommit = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state, every entry weakly not taken
    for (int k = 0; k < 6; k++) idle("R1 reset", 32'(k * 52));

    // R10 / R4: saturate upward then downward on one entry (ctxFlush keeps index fixed)
    for (int k = 0; k < 5; k++) step("R10 up", 0, 32'h40, 1, 32'h40, 1, 0, 0, 1);
    idle("R10 top", 32'h40);
    for (int k = 0; k < 5; k++) step("R10 down", 0, 32'h40, 1, 32'h40, 0, 0, 0, 1);
    idle("R10 bottom", 32'h40);

    // R9: retirement write and prediction read hit the same entry in one cycle
    step("R4 prime", 0, 32'h80, 1, 32'h80, 1, 0, 0, 1);
    step("R9 same-cycle", 1, 32'h80, 1, 32'h80, 1, 0, 0, 1);
    step("R9 after", 0, 32'h80, 0, 0, 0, 0, 0, 1);
    idle("R9 settled", 32'h80);

    // R6: a long run of predictions with no retirement leaves the table and commitHist alone
    for (int k = 0; k < 20; k++) step("R6 spec-only", 1, 32'(k * 4), 0, 0, 0, 0, 0, 0);
    step("R6 ctx", 0, 0, 0, 0, 0, 0, 0, 1);
    for (int k = 0; k < 20; k++) idle("R6 table intact", 32'(k * 4));

    // R7: mispredict flush alone and together with a retirement
    step("R5 commit", 0, 0, 1, 32'h100, 1, 0, 0, 0);
    step("R7 flush", 1, 32'h10, 0, 0, 0, 1, 1, 0);
    step("R7 flush+commit", 1, 32'h14, 1, 32'h104, 0, 1, 0, 0);
    idle("R7 after", 32'h14);

    // R8: context flush beats mispredict flush and retirement
    step("R8 ctx override", 1, 32'h20, 1, 32'h200, 1, 1, 1, 1);
    idle("R8 after", 32'h200);

    // random mix over a small PC pool to force collisions
    for (int k = 0; k < 4000; k++) begin
      bit [31:0] pa, pb;
      pa = 32'(($urandom % 12) * 4);
      pb = 32'(($urandom % 12) * 4);
      step("rand", ($urandom % 10) < 6, pa, ($urandom % 2) == 1, pb,
           ($urandom % 3) != 0, ($urandom % 10) == 0, ($urandom % 2) == 1,
           ($urandom % 40) == 0);
    end
    idle("final", 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule